// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store of `WORDS` entries, each `WIDTH` bits wide. It is looked up by content rather than by address. Two internal registers hold the search operand (the pattern) and a per-bit care mask. Each has its own load strobe. A lookup strobe compares the pattern against every stored entry in parallel. Only bit positions whose mask bit is 1 take part in the compare. The result is one hit bit per entry, captured in a register on that clock edge.

Entries are written through an addressed write port. A write stores the data and marks the row as occupied. Rows that were never written cannot hit. A read port follows the captured hit vector and returns the row number and current contents of the lowest-numbered hitting row. Two flags report on the last lookup: one for a lookup that found nothing and one for a lookup that found more than one row. Typical uses are tag lookup, and classification with don't-care fields.

Top module: `masked_cam`

## Requirements
- R1: A write (`wr_en`=1 at a rising edge) stores `wr_data` into row `wr_row` and marks that row occupied. A later lookup with the full mask and the same pattern hits that row.
- R2: At a position whose mask bit is 1, an entry bit matches only when it equals the pattern bit. An entry hits only when every such position matches.
- R3: A position whose mask bit is 0 always counts as matching. With an all-zero mask, every occupied row hits.
- R4: A row that has not been written since reset never hits. After reset, no row is occupied.
- R5: `hit_vec` (bit i is row i) is updated only at a rising edge where `lookup` is 1. The update uses the pattern, mask and storage as they stood before that edge. Otherwise `hit_vec` holds its value.
- R6: `pat_load` and `mask_load` load `pat_in` and `mask_in` at a rising edge. A load in the same cycle as a lookup affects only later lookups. A write in the same cycle as a lookup is likewise not seen by that lookup.
- R7: `rd_hit` is 1 when any bit of `hit_vec` is set. `rd_row` is then the lowest set index and `rd_data` is the current contents of that row. When `rd_hit` is 0, `rd_row` and `rd_data` are zero.
- R8: `multi_hit` is updated with `hit_vec`. It is 1 when the lookup found two or more rows.
- R9: `none_hit` is updated with `hit_vec`. It is 1 when the lookup found no row. Reset clears `hit_vec`, `multi_hit` and `none_hit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_load | input | 1 | Load strobe for the pattern register |
| pat_in | input | WIDTH | New pattern value |
| mask_load | input | 1 | Load strobe for the mask register |
| mask_in | input | WIDTH | New mask value (1 = compare this bit) |
| wr_en | input | 1 | Write strobe |
| wr_row | input | $clog2(WORDS) | Row to write |
| wr_data | input | WIDTH | Data to write |
| lookup | input | 1 | Lookup strobe |
| hit_vec | output | WORDS | Registered per-row hit bits |
| multi_hit | output | 1 | Last lookup hit two or more rows |
| none_hit | output | 1 | Last lookup hit no row |
| rd_hit | output | 1 | Some row hit |
| rd_row | output | $clog2(WORDS) | Lowest hitting row |
| rd_data | output | WIDTH | Contents of the lowest hitting row |

## Verification
The hardest situations to reach are the same-cycle collisions. One is a lookup issued in the same cycle as a write to a row it would hit; another is a lookup issued together with a pattern or mask load. In both, only the old values may count. Directed sequences set up these collisions on purpose. Random stimulus draws data from a narrow value range and uses sparse masks, so that multiple hits and empty results both occur often. The read port is also checked after a later write changes the contents of the reported row.

// File: rtl/masked_cam.sv
module masked_cam #(
  parameter int WORDS = 8,
  parameter int WIDTH = 8,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_load,
  input  logic [WIDTH-1:0] pat_in,
  input  logic             mask_load,
  input  logic [WIDTH-1:0] mask_in,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_row,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             lookup,
  output logic [WORDS-1:0] hit_vec,
  output logic             multi_hit,
  output logic             none_hit,
  output logic             rd_hit,
  output logic [AW-1:0]    rd_row,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [WORDS];
  logic [WORDS-1:0] occ;
  logic [WIDTH-1:0] pat_q, mask_q;
  logic [WORDS-1:0] cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_q  <= '0;
      mask_q <= '0;
    end else begin
      if (pat_load)  pat_q  <= pat_in;
      if (mask_load) mask_q <= mask_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else if (wr_en) occ[wr_row] <= 1'b1;
  end

  always_ff @(posedge clk)
    if (wr_en) mem[wr_row] <= wr_data;

  // each bit matches if equal (xnor) or not cared (~mask); row hits on AND of all bits
  for (genvar i = 0; i < WORDS; i++) begin : g_row
    assign cmp[i] = occ[i] & (&(~(pat_q ^ mem[i]) | ~mask_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_vec   <= '0;
      multi_hit <= 1'b0;
      none_hit  <= 1'b0;
    end else if (lookup) begin
      hit_vec   <= cmp;
      multi_hit <= ($countones(cmp) > 1);
      none_hit  <= (cmp == '0);
    end
  end

  always_comb begin
    rd_row = '0;
    for (int i = WORDS - 1; i >= 0; i--)
      if (hit_vec[i]) rd_row = AW'(i);
  end

  assign rd_hit  = |hit_vec;
  assign rd_data = rd_hit ? mem[rd_row] : '0;

  assert_unwritten_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~occ) == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup |=> $stable(hit_vec) && $stable(multi_hit) && $stable(none_hit));

  assert_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> occ[$past(wr_row)] && mem[$past(wr_row)] == $past(wr_data));

  assert_lowest_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> hit_vec[rd_row] && ((hit_vec & ((WORDS'(1) << rd_row) - WORDS'(1))) == '0));

  assert_multi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lookup |=> multi_hit == ($countones(hit_vec) > 1));

  assert_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lookup |=> none_hit == !rd_hit);

  assert_full_mask_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && mask_q == '1 && occ[0] && mem[0] != pat_q) |=> !hit_vec[0]);

  assert_zero_mask_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && mask_q == '0) |=> hit_vec == $past(occ));

endmodule

// File: tb/masked_cam_tb.sv
`timescale 1ns/1ps
module masked_cam_tb;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic pat_load, mask_load, wr_en, lookup;
  logic [W-1:0] pat_in, mask_in, wr_data;
  logic [AW-1:0] wr_row;
  logic [N-1:0] hit_vec;
  logic multi_hit, none_hit, rd_hit;
  logic [AW-1:0] rd_row;
  logic [W-1:0] rd_data;

  always #10 clk = ~clk;

  masked_cam #(.WORDS(N), .WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .pat_load(pat_load), .pat_in(pat_in),
    .mask_load(mask_load), .mask_in(mask_in),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .lookup(lookup),
    .hit_vec(hit_vec), .multi_hit(multi_hit), .none_hit(none_hit),
    .rd_hit(rd_hit), .rd_row(rd_row), .rd_data(rd_data)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [W-1:0] m_mem [N];
  logic [N-1:0] m_occ;
  logic [W-1:0] m_pat, m_mask;
  logic [N-1:0] e_vec;
  logic e_multi, e_none;

  function automatic logic [N-1:0] model_hits();
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++)
      v[i] = m_occ[i] && (((m_pat ^ m_mem[i]) & m_mask) == '0);
    return v;
  endfunction

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] ed;
    ed = (e_vec != '0) ? m_mem[lowest(e_vec)] : '0;
    chk(tag, "hit_vec", 32'(hit_vec), 32'(e_vec));
    chk("R8", "multi_hit", 32'(multi_hit), 32'(e_multi));
    chk("R9", "none_hit", 32'(none_hit), 32'(e_none));
    chk("R7", "rd_hit", 32'(rd_hit), 32'(e_vec != '0));
    chk("R7", "rd_row", 32'(rd_row), (e_vec != '0) ? 32'(lowest(e_vec)) : 32'd0);
    chk("R7", "rd_data", 32'(rd_data), 32'(ed));
  endtask

  task automatic op(input bit dw, input int row, input logic [W-1:0] d,
                    input bit dp, input logic [W-1:0] p,
                    input bit dm, input logic [W-1:0] m, input bit ds);
    logic [N-1:0] nv;
    wr_en = dw; wr_row = AW'(row); wr_data = d;
    pat_load = dp; pat_in = p; mask_load = dm; mask_in = m; lookup = ds;
    nv = model_hits();
    @(posedge clk);
    if (ds) begin
      e_vec = nv; e_multi = ($countones(nv) > 1); e_none = (nv == '0);
    end
    if (dw) begin m_mem[row] = d; m_occ[row] = 1'b1; end
    if (dp) m_pat = p;
    if (dm) m_mask = m;
    @(negedge clk);
    wr_en = 0; pat_load = 0; mask_load = 0; lookup = 0;
  endtask

  task automatic srch(input logic [W-1:0] p, input logic [W-1:0] m);
    op(0, 0, '0, 1, p, 1, m, 0);
    op(0, 0, '0, 0, '0, 0, '0, 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; pat_load = 0; mask_load = 0; wr_en = 0; lookup = 0;
    pat_in = '0; mask_in = '0; wr_data = '0; wr_row = '0;
    m_occ = '0; m_pat = '0; m_mask = '0; e_vec = '0; e_multi = 0; e_none = 0;
    for (int i = 0; i < N; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R9 reset");

    // R4: nothing written yet, even a don't-care lookup finds nothing
    srch(8'h00, 8'h00);
    check_all("R4");
    chk("R4", "none after reset", 32'(none_hit), 32'd1);

    // R1: write then exact lookup
    op(1, 5, 8'hA5, 0, '0, 0, '0, 0);
    srch(8'hA5, 8'hFF);
    check_all("R1");
    chk("R1", "row5 hit", 32'(hit_vec), 32'h20);

    // R2: one bit differs under a full mask -> miss
    srch(8'hA4, 8'hFF);
    check_all("R2");
    // R3: same bit masked off -> hit
    srch(8'hA4, 8'hFE);
    check_all("R3");
    chk("R3", "masked bit matches", 32'(rd_hit), 32'd1);

    // R8/R7: multiple hits, lowest reported
    op(1, 6, 8'hA5, 0, '0, 0, '0, 0);
    op(1, 2, 8'h35, 0, '0, 0, '0, 0);
    srch(8'h05, 8'h0F);
    check_all("R8");
    chk("R7", "lowest row", 32'(rd_row), 32'd2);
    // R3: zero mask hits every occupied row
    srch(8'h00, 8'h00);
    check_all("R3");
    chk("R3", "all occupied", 32'(hit_vec), 32'h64);

    // R6: pattern load in the same cycle as lookup uses the old pattern
    op(0, 0, '0, 1, 8'h35, 1, 8'hFF, 0);
    op(0, 0, '0, 1, 8'hA5, 0, '0, 1);
    check_all("R6");
    chk("R6", "old pattern", 32'(hit_vec), 32'h04);
    op(0, 0, '0, 0, '0, 0, '0, 1);
    check_all("R6");
    // R6: write in the same cycle as lookup not seen
    op(1, 0, 8'hA5, 0, '0, 0, '0, 1);
    check_all("R6");
    chk("R6", "write not seen", 32'(hit_vec), 32'h60);
    // R5: no lookup -> hold, but R7 read tracks content change
    op(1, 5, 8'h11, 0, '0, 0, '0, 0);
    check_all("R5");
    chk("R7", "rd_data follows write", 32'(rd_data), 32'h11);

    // random
    for (int k = 0; k < 400; k++) begin
      int r = $urandom % 8;
      logic [W-1:0] d = W'($urandom % 8) | W'(($urandom % 2) << 7);
      logic [W-1:0] mm = W'($urandom & $urandom);
      op(r < 3, int'($urandom % N), d, r == 3 || r == 7, W'($urandom % 8),
         r == 4 || r == 7, mm, r >= 4 || ($urandom % 4 == 0));
      check_all("R5");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule